// File: doc/BRIEF.md
# Banked Interrupt Source Controller

The controller collects up to five groups of 32 interrupt sources. Each group is called a bank. Each bank drives one interrupt line toward the processor. Every source first passes through a two-flop synchronizer. It is then qualified by its own trigger mode: active-high level, active-low level, rising edge or falling edge. The result becomes one bit of the bank's status word. A bank's line is raised whenever the status word ANDed with the bank's enable mask is nonzero. Next to the line, the bank presents the number of the lowest-numbered source in that AND, so the handler can pick what to service without scanning.

Software reaches the controller over a plain single-cycle register bus. A write is taken on the clock edge where `bus_wen` is high, and reads are combinational from `bus_addr`. Each bank holds six 32-bit words at byte offsets from its own base, which is the bank number times 24 (0x18):

| Offset | Word |
|---|---|
| 0x00 | status, read-only |
| 0x04 | enable mask |
| 0x08 | force-pending strobe |
| 0x0C | acknowledge strobe |
| 0x10 | polarity |
| 0x14 | edge select |

Global source i is bank i/32, bit i%32. On the input vector it is bit i.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, every line and every index output is 0, and the enable, polarity and edge words of every bank read as 0.
- R2: Bank b is at byte base b*0x18. The enable word is at offset 0x04, polarity at 0x10 and edge select at 0x14, and each reads back the value last written. A write to an address at or beyond the last bank's end changes nothing, and a read from such an address returns 0.
- R3: Polarity 1 with edge 0 selects active-high level: the status bit is 1 while the synchronized source is 1, and it returns to 0 when the source drops.
- R4: Polarity 0 with edge 0 selects active-low level: the status bit is 1 while the synchronized source is 0.
- R5: Polarity 1 with edge 1 selects rising edge. A 0-to-1 transition of the synchronized source sets the status bit, and the bit stays set after the source falls.
- R6: Polarity 0 with edge 1 selects falling edge. A 1-to-0 transition sets the status bit, and the bit stays set after the source rises.
- R7: Writing the acknowledge word (offset 0x0C) clears the held status of every bit written as 1 and leaves the bits written as 0 unchanged. A level-mode bit whose level is still active stays 1 after acknowledge.
- R8: Writing the force-pending word (offset 0x08) sets, on that clock edge, every status bit written as 1. The forced bit holds in every mode until it is acknowledged.
- R9: A bank's line is 1 exactly when the bank's status AND enable is nonzero.
- R10: A bank's 5-bit index equals the lowest set bit position of status AND enable, and it is 0 when that AND is zero.
- R11: The force-pending and acknowledge words read as 0. A write to the status word changes nothing.
- R12: A source change driven between clock edges first shows as level status after the second following rising edge, not after the first. An edge capture first shows after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_i | input | NUM_BANKS*32 | Raw interrupt sources, global number = bit index |
| bus_wen | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| cpu_irq_o | output | NUM_BANKS | One interrupt line per bank |
| src_idx_o | output | NUM_BANKS*5 | Lowest enabled pending source per bank, 5 bits per bank |

## Verification
Every bank is swept through all four trigger modes on its lowest, a middle and its highest bit. Each run watches for the cycle in which status first changes, which separates a missing or extra synchronizer stage and a mode whose polarity is swapped. The same runs check that a held edge capture survives the source returning idle while a level bit does not, and the acknowledge and force-pending tests separate bits written as 1 from bits written as 0. A ladder of force-pending patterns, in which every bit at or above k is set for each k, plus patterns that the enable mask trims, checks the index against the lowest-set position the bench computes itself.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int SRC_W       = 32;
  localparam int IDX_W       = 5;
  localparam int BANK_STRIDE = 24;

  typedef enum logic [4:0] {
    OFS_STATUS = 5'h00,
    OFS_ENABLE = 5'h04,
    OFS_FORCE  = 5'h08,
    OFS_ACK    = 5'h0C,
    OFS_POL    = 5'h10,
    OFS_EDGE   = 5'h14
  } reg_ofs_e;

  typedef struct packed {
    logic en;
    logic force_p;
    logic ack;
    logic pol;
    logic edg;
  } bank_wr_t;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [SRC_W-1:0] v);
    lowest_set = '0;
    for (int i = SRC_W - 1; i >= 0; i--)
      if (v[i]) lowest_set = IDX_W'(i);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_s,
  input  bank_wr_t         wstb,
  input  logic [SRC_W-1:0] wdata,
  output logic [SRC_W-1:0] status_o,
  output logic [SRC_W-1:0] enable_o,
  output logic [SRC_W-1:0] pol_o,
  output logic [SRC_W-1:0] edge_o,
  output logic             irq_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [SRC_W-1:0] en_q, pol_q, edg_q, held_q, prev_q;
  logic [SRC_W-1:0] rise, fall, det, lvl_act, set_w, clr_w, eff;

  // configuration words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
      edg_q <= '0;
    end else begin
      if (wstb.en)  en_q  <= wdata;
      if (wstb.pol) pol_q <= wdata;
      if (wstb.edg) edg_q <= wdata;
    end
  end

  // trigger detection on the synchronized sources
  assign rise    = src_s & ~prev_q;
  assign fall    = ~src_s & prev_q;
  assign det     = edg_q & ((pol_q & rise) | (~pol_q & fall));
  assign lvl_act = ~edg_q & ~(src_s ^ pol_q);
  assign set_w   = wstb.force_p ? wdata : '0;
  assign clr_w   = wstb.ack ? wdata : '0;

  // held status: edge captures and forced bits, released by acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      held_q <= '0;
    end else begin
      prev_q <= src_s;
      held_q <= (held_q & ~clr_w) | set_w | det;
    end
  end

  assign status_o = held_q | lvl_act;
  assign eff      = status_o & en_q;
  assign irq_o    = |eff;
  assign idx_o    = lowest_set(eff);
  assign enable_o = en_q;
  assign pol_o    = pol_q;
  assign edge_o   = edg_q;

  // R5 R6: held bits survive unless acknowledged
  p_held_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(held_q) & ~$past(clr_w) & ~held_q) == '0));

  // R7: acknowledged bits drop unless re-triggered in the same cycle
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w != '0) |=> ((held_q & $past(clr_w & ~set_w & ~det)) == '0));

  // R8: forced bits show as pending on the next cycle
  p_force_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w != '0) |=> ((status_o & $past(set_w)) == $past(set_w)));

  // R9: no line while nothing is enabled
  p_quiet_when_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);

  // R10: reported source is enabled, pending and lowest
  p_idx_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o[idx_o] && en_q[idx_o]));
  p_idx_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((status_o & en_q & ((SRC_W'(1) << idx_o) - SRC_W'(1))) == '0));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS*SRC_W-1:0] src_i,
  input  logic                       bus_wen,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [SRC_W-1:0]           bus_wdata,
  output logic [SRC_W-1:0]           bus_rdata,
  output logic [NUM_BANKS-1:0]       cpu_irq_o,
  output logic [NUM_BANKS*IDX_W-1:0] src_idx_o
);
  localparam int TOTAL_SRC = NUM_BANKS * SRC_W;

  logic [TOTAL_SRC-1:0] src_s;
  logic [ADDR_W-1:0]    sel_bank, sel_ofs;
  logic [SRC_W-1:0]     rd_word [NUM_BANKS];

  assign sel_bank = bus_addr / ADDR_W'(BANK_STRIDE);
  assign sel_ofs  = bus_addr % ADDR_W'(BANK_STRIDE);

  irq_sync #(.W(TOTAL_SRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (src_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_wr_t         stb;
    logic             sel;
    logic [SRC_W-1:0] st, en, pl, ed;

    assign sel = bus_wen && (sel_bank == ADDR_W'(b));

    always_comb begin
      stb.en      = sel && (sel_ofs == ADDR_W'(OFS_ENABLE));
      stb.force_p = sel && (sel_ofs == ADDR_W'(OFS_FORCE));
      stb.ack     = sel && (sel_ofs == ADDR_W'(OFS_ACK));
      stb.pol     = sel && (sel_ofs == ADDR_W'(OFS_POL));
      stb.edg     = sel && (sel_ofs == ADDR_W'(OFS_EDGE));
    end

    irq_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_s    (src_s[b*SRC_W +: SRC_W]),
      .wstb     (stb),
      .wdata    (bus_wdata),
      .status_o (st),
      .enable_o (en),
      .pol_o    (pl),
      .edge_o   (ed),
      .irq_o    (cpu_irq_o[b]),
      .idx_o    (src_idx_o[b*IDX_W +: IDX_W])
    );

    always_comb begin
      case (sel_ofs)
        ADDR_W'(OFS_STATUS): rd_word[b] = st;
        ADDR_W'(OFS_ENABLE): rd_word[b] = en;
        ADDR_W'(OFS_POL):    rd_word[b] = pl;
        ADDR_W'(OFS_EDGE):   rd_word[b] = ed;
        default:             rd_word[b] = '0;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (sel_bank == ADDR_W'(b)) bus_rdata = rd_word[b];
  end

  // R11: strobe words never read back nonzero
  always_comb begin
    if (rst_n && (sel_ofs == ADDR_W'(OFS_FORCE) || sel_ofs == ADDR_W'(OFS_ACK)))
      p_strobe_reads_zero_r11: assert (bus_rdata == '0);
  end
endmodule

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  localparam int NB = 5;
  localparam int AW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NB*32-1:0]  src = '0;
  logic              bus_wen = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NB-1:0]     cpu_irq;
  logic [NB*5-1:0]   idx;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_irq_o (cpu_irq),
    .src_idx_o (idx)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    bus_addr = AW'(a);
    #1 v = bus_rdata;
  endtask

  function automatic logic [4:0] low_bit(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  function automatic logic [4:0] idx_of(input int b);
    return idx[b*5 +: 5];
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    tick(3);
    rst_n = 1'b1;
    tick(3);

    // R1 reset state
    check("R1 lines", 32'(cpu_irq), 32'h0);
    check("R1 idx", 32'(idx), 32'h0);
    for (int b = 0; b < NB; b++) begin
      rd(b*24 + 4, v);  check("R1 enable", v, 0);
      rd(b*24 + 16, v); check("R1 pol", v, 0);
      rd(b*24 + 20, v); check("R1 edge", v, 0);
    end

    // R2 address map readback
    for (int b = 0; b < NB; b++) begin
      wr(b*24 + 4,  32'h1234_0000 ^ 32'(b));
      wr(b*24 + 16, 32'hA5A5_0F00 ^ 32'(b << 8));
      wr(b*24 + 20, 32'h0FF0_00C3 ^ 32'(b << 20));
    end
    for (int b = 0; b < NB; b++) begin
      rd(b*24 + 4, v);  check("R2 enable", v, 32'h1234_0000 ^ 32'(b));
      rd(b*24 + 16, v); check("R2 pol", v, 32'hA5A5_0F00 ^ 32'(b << 8));
      rd(b*24 + 20, v); check("R2 edge", v, 32'h0FF0_00C3 ^ 32'(b << 20));
    end
    wr(NB*24 + 4, 32'hFFFF_FFFF);
    rd(NB*24 + 4, v); check("R2 out of range read", v, 0);
    rd((NB-1)*24 + 4, v); check("R2 out of range write", v, 32'h1234_0000 ^ 32'(NB-1));
    for (int b = 0; b < NB; b++) begin
      wr(b*24 + 4, 0); wr(b*24 + 16, 0); wr(b*24 + 20, 0); wr(b*24 + 12, 32'hFFFF_FFFF);
    end

    // R3..R6, R12 mode sweep: mode bit1=edge, bit0=pol
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < 3; k++) begin
        for (int m = 0; m < 4; m++) begin
          int bit_n;
          logic pol, edg, idle;
          string rq;
          bit_n = (k == 0) ? 0 : (k == 1) ? 13 : 31;
          pol = m[0]; edg = m[1]; idle = ~pol;
          rq = (m == 1) ? "R3" : (m == 0) ? "R4" : (m == 3) ? "R5" : "R6";
          base = b*24;
          src = '0; src[b*32 + bit_n] = idle;
          tick(4);
          wr(base + 16, 32'(pol) << bit_n);
          wr(base + 20, 32'(edg) << bit_n);
          wr(base + 4, 32'd1 << bit_n);
          wr(base + 12, 32'hFFFF_FFFF);
          rd(base, v); check({rq, " idle status"}, 32'(v[bit_n]), 0);
          check("R9 idle line", 32'(cpu_irq[b]), 0);
          src[b*32 + bit_n] = ~idle;
          tick(1);
          rd(base, v); check("R12 one edge", 32'(v[bit_n]), 0);
          tick(1);
          rd(base, v); check({rq, " R12 two edges"}, 32'(v[bit_n]), edg ? 0 : 1);
          tick(1);
          rd(base, v); check({rq, " active"}, 32'(v[bit_n]), 1);
          check("R9 line", 32'(cpu_irq[b]), 1);
          check("R10 idx", 32'(idx_of(b)), 32'(bit_n));
          src[b*32 + bit_n] = idle;
          tick(3);
          rd(base, v); check({rq, " after release"}, 32'(v[bit_n]), edg ? 1 : 0);
          wr(base + 12, 32'd1 << bit_n);
          rd(base, v); check("R7 ack", 32'(v[bit_n]), 0);
          check("R9 line after ack", 32'(cpu_irq[b]), 0);
          wr(base + 4, 0); wr(base + 16, 0); wr(base + 20, 0);
        end
      end
    end
    src = '0;
    tick(3);

    // R7 level stays pending through ack
    wr(16, 32'd1 << 5); wr(4, 32'd1 << 5);
    src[5] = 1'b1; tick(3);
    wr(12, 32'd1 << 5);
    rd(0, v); check("R7 level held", 32'(v[5]), 1);
    src[5] = 1'b0; tick(3);
    rd(0, v); check("R3 level release", 32'(v[5]), 0);

    // R7 zero bits leave captures alone
    wr(16, 32'd1 << 9); wr(20, 32'd1 << 9); wr(4, 32'd1 << 9);
    src[9] = 1'b1; tick(3); src[9] = 1'b0; tick(3);
    wr(12, 32'hFFFF_FDFF);
    rd(0, v); check("R7 zero bits", 32'(v[9]), 1);
    wr(12, 32'd1 << 9);
    rd(0, v); check("R7 one bit", 32'(v[9]), 0);
    wr(4, 0); wr(16, 0); wr(20, 0);

    // R8 force pending on a level-high bit with idle source
    wr(24 + 16, 32'd1 << 7); wr(24 + 4, 32'd1 << 7);
    tick(2);
    rd(24, v); check("R8 before", 32'(v[7]), 0);
    wr(24 + 8, 32'd1 << 7);
    rd(24, v); check("R8 forced", 32'(v[7]), 1);
    check("R9 forced line", 32'(cpu_irq[1]), 1);
    check("R10 forced idx", 32'(idx_of(1)), 7);
    tick(3);
    rd(24, v); check("R8 held", 32'(v[7]), 1);
    wr(24 + 12, 32'd1 << 7);
    rd(24, v); check("R8 acked", 32'(v[7]), 0);
    wr(24 + 4, 0); wr(24 + 16, 0);

    // R11 strobes read zero, status not writable
    wr(48 + 16, 32'hFFFF_FFFF); wr(48 + 20, 32'hFFFF_FFFF);
    wr(48 + 12, 32'hFFFF_FFFF);
    wr(48, 32'hFFFF_FFFF);
    rd(48, v); check("R11 status write", v, 0);
    wr(48 + 8, 32'h0000_F00F);
    rd(48 + 8, v);  check("R11 force reads 0", v, 0);
    rd(48 + 12, v); check("R11 ack reads 0", v, 0);
    rd(48, v); check("R8 forced word", v, 32'h0000_F00F);
    wr(48 + 12, 32'hFFFF_FFFF);

    // R10 priority ladder on bank 3 (all rising edge, sources idle)
    base = 72;
    wr(base + 16, 32'hFFFF_FFFF); wr(base + 20, 32'hFFFF_FFFF);
    wr(base + 4, 32'hFFFF_FFFF);
    for (int k = 0; k < 32; k++) begin
      logic [31:0] p;
      p = 32'hFFFF_FFFF << k;
      wr(base + 12, 32'hFFFF_FFFF);
      wr(base + 8, p);
      check("R10 ladder idx", 32'(idx_of(3)), 32'(k));
      check("R9 ladder line", 32'(cpu_irq[3]), 1);
    end
    for (int t = 0; t < 5; t++) begin
      logic [31:0] p, e;
      case (t)
        0: begin p = 32'h0000_0000; e = 32'hFFFF_FFFF; end
        1: begin p = 32'h00F0_0100; e = 32'hFFFF_FEFF; end
        2: begin p = 32'hFFFF_FFFF; e = 32'h4000_0000; end
        3: begin p = 32'h8000_0001; e = 32'h7FFF_FFFE; end
        default: begin p = 32'h0100_0410; e = 32'h0100_0400; end
      endcase
      wr(base + 12, 32'hFFFF_FFFF);
      wr(base + 4, e);
      wr(base + 8, p);
      check("R9 masked line", 32'(cpu_irq[3]), 32'((p & e) != 0));
      check("R10 masked idx", 32'(idx_of(3)), 32'(low_bit(p & e)));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule